// File: doc/BRIEF.md
# CAN Transmit Mailbox Priority Selector

This block decides which transmit mailbox a CAN node should send next. Mailboxes 1 to 15 can request transmission. A mailbox is a candidate when it is pending and has been configured for transmit. Mailbox 0 is a receive-only slot and is never chosen. Each mailbox supplies its own identifier fields: an 11-bit base identifier, an extended-format flag, an 18-bit identifier extension, and a remote-frame flag.

Two orderings are available, and a mode bit chooses between them. In identifier ordering, the candidates are ranked the way simultaneous transmitters would be ranked by bus arbitration: the smallest comparison key wins. In number ordering, the highest-numbered candidate wins. The mode bit can only be loaded while the controller reports that it is in reset or halt. Loads at any other time are dropped.

The result is a plain registered index with a valid flag. It tracks its inputs with one clock of latency. There is no handshake: the transmit engine samples the result whenever it is ready to start a frame.

Top module: `can_tx_prio_sel`

## Requirements
- R1: Mailbox i (1 to NUM_MB-1) is a candidate only when both `pend_i[i]` and `tx_en_i[i]` are 1. Mailbox 0 is never reported, even when it is pending and enabled.
- R2: `sel_valid_o` and `sel_idx_o` are registers. They reflect the inputs and the mode present at the previous rising clock edge. A change in the inputs is therefore not visible until after the next edge.
- R3: With `mode_o` = 1 (number ordering), the highest-numbered candidate is selected.
- R4: With `mode_o` = 0 (identifier ordering), the candidate with the numerically lowest 31-bit key is selected. The key is formed as {base ID[10:0], IDE, IDE ? extension[17:0] : 0, RTR}, with the base ID at the most significant end.
- R5: When a mailbox's IDE bit is 0, its extension field has no effect on its key.
- R6: In identifier ordering, when two candidates have equal keys, the higher-numbered mailbox wins.
- R7: `mode_o` resets to 0. On a rising edge where `mode_wr_i` = 1 and `cfg_ok_i` = 1, it loads `mode_wd_i`. When `mode_wr_i` = 1 but `cfg_ok_i` = 0, the write is ignored.
- R8: When there is no candidate, `sel_valid_o` is 0 and `sel_idx_o` is 0.
- R9: While `rst_n` is low, `sel_valid_o` is 0 and `sel_idx_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pend_i | input | NUM_MB | Transmit request per mailbox |
| tx_en_i | input | NUM_MB | Mailbox configured for transmit |
| std_id_i | input | NUM_MB*STD_W | Base identifiers, mailbox i at bits [i*STD_W +: STD_W] |
| ide_i | input | NUM_MB | Extended-format flag per mailbox |
| ext_id_i | input | NUM_MB*EXT_W | Identifier extensions, mailbox i at bits [i*EXT_W +: EXT_W] |
| rtr_i | input | NUM_MB | Remote-frame flag per mailbox |
| mode_wr_i | input | 1 | Request to load the ordering mode |
| mode_wd_i | input | 1 | Mode value: 0 = identifier order, 1 = number order |
| cfg_ok_i | input | 1 | Controller is in reset or halt; mode loads allowed |
| mode_o | output | 1 | Current ordering mode |
| sel_valid_o | output | 1 | A candidate was found |
| sel_idx_o | output | $clog2(NUM_MB) | Winning mailbox number |

## Verification
The bench builds the block with its default parameters: 16 mailbox slots, an 11-bit base ID and an 18-bit extension. At these widths every field of the 31-bit key is reachable.

With these values the bench can do three things:
- place a winner at the top slot, 15, and confirm that slot 0 is excluded;
- create key ties that differ only in ignored extension bits;
- build pairs whose keys differ only in the IDE or RTR position.

Mode loads are attempted both with and without the configuration permission.

// File: rtl/can_sel_pkg.sv
package can_sel_pkg;
  typedef enum logic {
    PRIO_BY_ID  = 1'b0,
    PRIO_BY_NUM = 1'b1
  } prio_mode_e;
endpackage

// File: rtl/can_key_build.sv
module can_key_build #(
  parameter int STD_W = 11,
  parameter int EXT_W = 18,
  localparam int KEY_W = STD_W + EXT_W + 2
) (
  input  logic [STD_W-1:0] std_id,
  input  logic             ide,
  input  logic [EXT_W-1:0] ext_id,
  input  logic             rtr,
  output logic [KEY_W-1:0] key
);
  logic [EXT_W-1:0] ext_used;

  always_comb begin
    ext_used = ide ? ext_id : '0;
    key      = {std_id, ide, ext_used, rtr};
  end
endmodule

// File: rtl/can_mode_reg.sv
module can_mode_reg
  import can_sel_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr,
  input  logic       wdata,
  input  logic       cfg_ok,
  output prio_mode_e mode_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      mode_q <= PRIO_BY_ID;
    else if (wr && cfg_ok)
      mode_q <= prio_mode_e'(wdata);
  end
endmodule

// File: rtl/can_sel_pick.sv
module can_sel_pick
  import can_sel_pkg::*;
#(
  parameter int NUM_MB = 16,
  parameter int KEY_W  = 31,
  localparam int IDX_W = $clog2(NUM_MB)
) (
  input  logic [NUM_MB-1:0] cand,
  input  logic [KEY_W-1:0]  key_a [NUM_MB],
  input  prio_mode_e        mode,
  output logic              win_valid,
  output logic [IDX_W-1:0]  win_idx
);
  logic [KEY_W-1:0] best_key;

  // Ascending scan: a later candidate replaces the current best on an equal
  // key, so ties resolve to the higher mailbox; in number order every later
  // candidate replaces it, so the highest number wins.
  always_comb begin
    best_key  = '0;
    win_idx   = '0;
    win_valid = 1'b0;
    for (int i = 1; i < NUM_MB; i++) begin
      if (cand[i] && (!win_valid || mode == PRIO_BY_NUM || key_a[i] <= best_key)) begin
        win_valid = 1'b1;
        best_key  = key_a[i];
        win_idx   = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/can_tx_prio_sel.sv
module can_tx_prio_sel
  import can_sel_pkg::*;
#(
  parameter int NUM_MB = 16,
  parameter int STD_W  = 11,
  parameter int EXT_W  = 18,
  localparam int IDX_W = $clog2(NUM_MB),
  localparam int KEY_W = STD_W + EXT_W + 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [NUM_MB-1:0]       pend_i,
  input  logic [NUM_MB-1:0]       tx_en_i,
  input  logic [NUM_MB*STD_W-1:0] std_id_i,
  input  logic [NUM_MB-1:0]       ide_i,
  input  logic [NUM_MB*EXT_W-1:0] ext_id_i,
  input  logic [NUM_MB-1:0]       rtr_i,
  input  logic                    mode_wr_i,
  input  logic                    mode_wd_i,
  input  logic                    cfg_ok_i,
  output logic                    mode_o,
  output logic                    sel_valid_o,
  output logic [IDX_W-1:0]        sel_idx_o
);
  prio_mode_e       mode_q;
  logic [KEY_W-1:0] key_a [NUM_MB];
  logic [NUM_MB-1:0] cand;
  logic             win_valid;
  logic [IDX_W-1:0] win_idx;

  can_mode_reg u_mode (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr     (mode_wr_i),
    .wdata  (mode_wd_i),
    .cfg_ok (cfg_ok_i),
    .mode_q (mode_q)
  );

  for (genvar g = 0; g < NUM_MB; g++) begin : g_key
    can_key_build #(.STD_W(STD_W), .EXT_W(EXT_W)) u_key (
      .std_id (std_id_i[g*STD_W +: STD_W]),
      .ide    (ide_i[g]),
      .ext_id (ext_id_i[g*EXT_W +: EXT_W]),
      .rtr    (rtr_i[g]),
      .key    (key_a[g])
    );
  end

  assign cand = pend_i & tx_en_i;

  can_sel_pick #(.NUM_MB(NUM_MB), .KEY_W(KEY_W)) u_pick (
    .cand      (cand),
    .key_a     (key_a),
    .mode      (mode_q),
    .win_valid (win_valid),
    .win_idx   (win_idx)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_valid_o <= 1'b0;
      sel_idx_o   <= '0;
    end else begin
      sel_valid_o <= win_valid;
      sel_idx_o   <= win_idx;
    end
  end

  assign mode_o = mode_q;
endmodule

// File: rtl/can_tx_prio_sel_chk.sv
module can_tx_prio_sel_chk #(
  parameter int NUM_MB = 16,
  localparam int IDX_W = $clog2(NUM_MB)
) (
  input logic              clk,
  input logic              rst_n,
  input logic [NUM_MB-1:0] pend_i,
  input logic [NUM_MB-1:0] tx_en_i,
  input logic              mode_wr_i,
  input logic              cfg_ok_i,
  input logic              mode_o,
  input logic              sel_valid_o,
  input logic [IDX_W-1:0]  sel_idx_o
);
  logic [NUM_MB-1:0] cand_d;
  logic              mode_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cand_d <= '0;
      mode_d <= 1'b0;
    end else begin
      cand_d <= pend_i & tx_en_i;
      mode_d <= mode_o;
    end
  end

  AST_NEVER_SLOT0: assert property (@(posedge clk) disable iff (!rst_n)
    sel_valid_o |-> sel_idx_o != '0); // R1
  AST_WINNER_IS_CAND: assert property (@(posedge clk) disable iff (!rst_n)
    sel_valid_o |-> cand_d[sel_idx_o]); // R2
  AST_NUM_ORDER_TOP: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_valid_o && mode_d) |-> ((cand_d >> sel_idx_o) >> 1) == '0); // R3
  AST_MODE_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_wr_i && !cfg_ok_i) |=> $stable(mode_o)); // R7
  AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !sel_valid_o |-> sel_idx_o == '0); // R8
  AST_NONE_INVALID: assert property (@(posedge clk) disable iff (!rst_n)
    (cand_d[NUM_MB-1:1] == '0) |-> !sel_valid_o); // R8
endmodule

bind can_tx_prio_sel can_tx_prio_sel_chk #(.NUM_MB(NUM_MB)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .pend_i      (pend_i),
  .tx_en_i     (tx_en_i),
  .mode_wr_i   (mode_wr_i),
  .cfg_ok_i    (cfg_ok_i),
  .mode_o      (mode_o),
  .sel_valid_o (sel_valid_o),
  .sel_idx_o   (sel_idx_o)
);

// File: tb/can_tx_prio_sel_bench.sv
module can_tx_prio_sel_bench;
  localparam int NUM_MB = 16;
  localparam int STD_W  = 11;
  localparam int EXT_W  = 18;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NUM_MB-1:0] pend = '0, en = '0, ide_v, rtr_v;
  logic [NUM_MB*STD_W-1:0] std_flat;
  logic [NUM_MB*EXT_W-1:0] ext_flat;
  logic mode_wr = 1'b0, mode_wd = 1'b0, cfg_ok = 1'b0;
  logic mode_o, sel_valid;
  logic [3:0] sel_idx;

  logic [STD_W-1:0] std_a [NUM_MB];
  logic [EXT_W-1:0] ext_a [NUM_MB];
  logic             ide_a [NUM_MB];
  logic             rtr_a [NUM_MB];

  int checks = 0, fails = 0;

  always #4 clk = ~clk;

  always_comb begin
    for (int i = 0; i < NUM_MB; i++) begin
      std_flat[i*STD_W +: STD_W] = std_a[i];
      ext_flat[i*EXT_W +: EXT_W] = ext_a[i];
      ide_v[i] = ide_a[i];
      rtr_v[i] = rtr_a[i];
    end
  end

  can_tx_prio_sel u_can_tx_prio_sel (
    .clk(clk), .rst_n(rst_n), .pend_i(pend), .tx_en_i(en),
    .std_id_i(std_flat), .ide_i(ide_v), .ext_id_i(ext_flat), .rtr_i(rtr_v),
    .mode_wr_i(mode_wr), .mode_wd_i(mode_wd), .cfg_ok_i(cfg_ok),
    .mode_o(mode_o), .sel_valid_o(sel_valid), .sel_idx_o(sel_idx)
  );

  // {pend, en, mode, exp_valid, exp_idx}; base ID of mailbox i is i*16
  localparam logic [37:0] VEC [8] = '{
    {16'h0006, 16'hFFFF, 1'b0, 1'b1, 4'd1},
    {16'h0006, 16'hFFFF, 1'b1, 1'b1, 4'd2},
    {16'h8421, 16'hFFFF, 1'b0, 1'b1, 4'd5},
    {16'h8421, 16'hFFFF, 1'b1, 1'b1, 4'd15},
    {16'h8421, 16'h7FFF, 1'b1, 1'b1, 4'd10},
    {16'h0001, 16'hFFFF, 1'b0, 1'b0, 4'd0},
    {16'hFFFF, 16'h0000, 1'b1, 1'b0, 4'd0},
    {16'hF000, 16'hA000, 1'b0, 1'b1, 4'd13}
  };

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic default_ids();
    for (int i = 0; i < NUM_MB; i++) begin
      std_a[i] = STD_W'(i * 16);
      ext_a[i] = '0;
      ide_a[i] = 1'b0;
      rtr_a[i] = 1'b0;
    end
  endtask

  task automatic load_mode(bit m);
    @(negedge clk);
    cfg_ok = 1'b1; mode_wr = 1'b1; mode_wd = m;
    @(negedge clk);
    cfg_ok = 1'b0; mode_wr = 1'b0;
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    default_ids();
    pend = 16'hFFFF; en = 16'hFFFF;
    repeat (3) @(negedge clk);
    check("R9 valid in reset", sel_valid, 0);
    check("R9 idx in reset", sel_idx, 0);
    rst_n = 1'b1;
    pend = '0;
    @(negedge clk);
    check("R7 mode reset value", mode_o, 0);

    for (int v = 0; v < 8; v++) begin
      load_mode(VEC[v][5]);
      pend = VEC[v][37:22]; en = VEC[v][21:6];
      @(negedge clk);
      check($sformatf("R1 R3 R4 R8 vec%0d valid", v), sel_valid, VEC[v][4]);
      check($sformatf("R1 R3 R4 R8 vec%0d idx", v), sel_idx, VEC[v][3:0]);
    end

    // R2: no change before the edge, change after it
    load_mode(1'b0);
    pend = 16'h0010; en = 16'hFFFF;
    @(negedge clk);
    check("R2 settled", sel_idx, 4);
    pend = 16'h0110;
    #1;
    check("R2 before edge", sel_idx, 4);
    @(negedge clk);
    check("R2 after edge", sel_idx, 4);
    pend = 16'h0100;
    @(negedge clk);
    check("R2 follows inputs", sel_idx, 8);

    // R4: RTR versus IDE position
    std_a[3] = 11'd5; rtr_a[3] = 1'b1;
    std_a[4] = 11'd5;
    pend = 16'h0018;
    @(negedge clk);
    check("R4 rtr=0 wins", sel_idx, 4);
    ide_a[4] = 1'b1;
    @(negedge clk);
    check("R4 ide below rtr", sel_idx, 3);
    ide_a[3] = 1'b1; rtr_a[3] = 1'b0; ext_a[3] = 18'd100; ext_a[4] = 18'd50;
    @(negedge clk);
    check("R4 extension compare", sel_idx, 4);

    // R5 and R6
    default_ids();
    std_a[2] = 11'd7; std_a[9] = 11'd7;
    ext_a[9] = 18'h3FFFF;
    pend = 16'h0204;
    @(negedge clk);
    check("R5 ext ignored when ide=0", sel_idx, 9);
    ext_a[9] = '0;
    std_a[4] = 11'd1; std_a[11] = 11'd1;
    pend = 16'h0810;
    @(negedge clk);
    check("R6 tie to higher mailbox", sel_idx, 11);

    // R7 lock
    default_ids();
    pend = 16'h0006;
    @(negedge clk);
    mode_wr = 1'b1; mode_wd = 1'b1; cfg_ok = 1'b0;
    @(negedge clk);
    mode_wr = 1'b0;
    check("R7 locked write mode", mode_o, 0);
    @(negedge clk);
    check("R7 locked write selection", sel_idx, 1);
    load_mode(1'b1);
    check("R7 permitted write", mode_o, 1);
    @(negedge clk);
    check("R7 new order applies", sel_idx, 2);

    summary();
  end
endmodule